// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine

This block is one DMA channel that copies bytes between memory regions, or between memory and a peripheral register, over a byte-wide bus. It shares the bus with another master, which always has priority. The channel asks for the bus, waits for a grant and then keeps the bus for one whole burst. In each burst it first reads up to eight bytes into an internal buffer. It then writes those bytes to the destination in the same order. Between bursts it releases the bus for at least one cycle.

Software loads the configuration through parallel inputs and pulses `arm`. The configuration covers burst size, block size, repeat count, trigger selection, and the address stepping and reload policy for each side. A transfer request then starts the movement. The request comes from the software strobe or from a selected hardware trigger line. A request moves either one burst (single-shot) or one whole block. A transaction is one block, or a counted or endless series of blocks. At the end of the transaction the channel drops its enable and pulses `done_o`. Pulsing `disarm` stops the channel early and reports an abort.

Top module: `dma_channel`

## Requirements
- R1: A burst owns the bus without a break. `bus_req` stays high from the first read of a burst to its last write. It goes low for at least one cycle after every burst before the next one requests the bus.
- R2: A burst's first read is issued only in the cycle after `bus_gnt` was sampled high. While the grant is held low, the channel keeps `bus_req` high and issues no read. Once the first read is issued, a grant that falls mid-burst does not stop the burst.
- R3: `cfg_bl` selects the burst size: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. All reads of a burst come first, then all writes in the same byte order. When fewer bytes than the burst size are left in a block, the last burst of that block is shortened to the remainder.
- R4: `cfg_blk_cnt` gives the block size in bytes, from 1 to 65535. A value of 0 means 65536 bytes. The remaining count is restored to the configured value after every block, so each block of a transaction has the same length.
- R5: With `cfg_rpt`=1, a transaction has `cfg_rep_cnt` blocks, and 0 means the blocks repeat without end. `rpt_o` falls when the last block begins. With `cfg_rpt`=0, a transaction is exactly one block.
- R6: `ch_en_o` goes low when the transaction's last write has finished, and `done_o` is high for exactly one cycle at that moment. The pending request flag `req_o` clears when a transfer begins.
- R7: Each side has its own address mode: 0 keeps the address fixed, 1 increments it by one, 2 decrements it by one, and 3 keeps it fixed. The address steps after every byte on that side.
- R8: Each side has its own reload policy, which restores the start address. 0 never reloads. 1 reloads after every burst. 2 reloads after every block. 3 reloads only after the whole transaction, so the address carries on across block boundaries.
- R9: With `cfg_ss`=1, each request moves exactly one burst. With `cfg_ss`=0, each request moves one whole block.
- R10: `cfg_trig_sel`=0 disables hardware triggering. A value k from 1 to NTRIG makes a rising edge on `hw_trig[k-1]` a request, and edges on the other lines are ignored. `sw_req` is always a request while the channel is enabled.
- R11: `arm` is accepted only while the channel is disabled and idle. An `arm` pulse while the channel is enabled changes none of the active configuration, including the single-shot setting.
- R12: A `disarm` pulse while the channel is enabled clears `ch_en_o` and pulses `abort_o` for one cycle. `done_o` does not pulse for that transaction.
- R13: After reset, `bus_req`, `bus_rd`, `bus_wr`, `busy_o`, `ch_en_o`, `rpt_o`, `req_o`, `done_o` and `abort_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Load configuration and enable the channel |
| disarm | input | 1 | Abort and disable the channel |
| cfg_ss | input | 1 | One burst per request when high |
| cfg_rpt | input | 1 | Multi-block transaction enable |
| cfg_bl | input | 2 | Burst size code |
| cfg_src_mode | input | 2 | Source address step mode |
| cfg_dst_mode | input | 2 | Destination address step mode |
| cfg_src_rld | input | 2 | Source reload policy |
| cfg_dst_rld | input | 2 | Destination reload policy |
| cfg_blk_cnt | input | 16 | Bytes per block, 0 meaning 65536 |
| cfg_rep_cnt | input | 8 | Blocks per transaction, 0 meaning endless |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_trig_sel | input | TSW | Hardware trigger line select, 0 meaning none |
| sw_req | input | 1 | Software transfer request strobe |
| hw_trig | input | NTRIG | Hardware trigger lines |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe; data is returned one cycle later |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| ch_en_o | output | 1 | Channel enabled |
| rpt_o | output | 1 | Repeat flag still set |
| req_o | output | 1 | Transfer request pending |
| busy_o | output | 1 | Waiting for the bus or moving a burst |
| done_o | output | 1 | One-cycle transaction complete pulse |
| abort_o | output | 1 | One-cycle abort pulse |

## Verification
A wrong byte counter or a bad burst-size pick shows up at the ports within one burst. The run of consecutive `bus_wr` cycles has the wrong length, or the last burst of a block is not shortened. A corrupted address register or a reload applied at the wrong moment shows up as soon as the next burst: the destination bytes come from the wrong source offsets. A stale repeat or block counter shows up only at a block boundary. There, `rpt_o` falls one block early or late, or `done_o` comes too early or never comes. For this reason the multi-block scenarios check `rpt_o` both before and after the last block starts.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW    = 16,
  parameter int NTRIG = 4,
  parameter int TSW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             disarm,
  input  logic             cfg_ss,
  input  logic             cfg_rpt,
  input  logic [1:0]       cfg_bl,
  input  logic [1:0]       cfg_src_mode,
  input  logic [1:0]       cfg_dst_mode,
  input  logic [1:0]       cfg_src_rld,
  input  logic [1:0]       cfg_dst_rld,
  input  logic [15:0]      cfg_blk_cnt,
  input  logic [7:0]       cfg_rep_cnt,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [TSW-1:0]   cfg_trig_sel,
  input  logic             sw_req,
  input  logic [NTRIG-1:0] hw_trig,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             ch_en_o,
  output logic             rpt_o,
  output logic             req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o
);

  localparam int BCW = 17;
  localparam int IW  = 4;
  localparam int BUF = 8;
  localparam logic [1:0] RLD_BURST = 2'd1;
  localparam logic [1:0] RLD_BLOCK = 2'd2;
  localparam logic [1:0] RLD_TXN   = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_RDL, S_WR, S_END} st_t;

  st_t            st;
  logic           en_q, rpt_q, req_q, ss_q, blk_act, done_q, abort_q;
  logic [1:0]     bl_q, smode, dmode, srld, drld;
  logic [15:0]    blk_init;
  logic [BCW-1:0] blk_left;
  logic [7:0]     rep_left;
  logic [AW-1:0]  src_init, dst_init, src_cur, dst_cur;
  logic [TSW-1:0] tsel_q;
  logic           trig_hit, trig_prev;
  logic [IW-1:0]  idx, bn;
  logic [7:0]     buf_q [0:BUF-1];
  logic           rd_q;
  logic [2:0]     cap_idx;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      2'd1:    step = a + {{(AW-1){1'b0}}, 1'b1};
      2'd2:    step = a - {{(AW-1){1'b0}}, 1'b1};
      default: step = a;
    endcase
  endfunction

  always_comb begin
    trig_hit = 1'b0;
    for (int k = 0; k < NTRIG; k++)
      if (tsel_q == TSW'(k + 1)) trig_hit = hw_trig[k];
  end

  wire [IW-1:0] blen     = IW'(1) << bl_q;
  wire [IW-1:0] bn_next  = (blk_left < {{(BCW-IW){1'b0}}, blen}) ? blk_left[IW-1:0] : blen;
  wire          new_req  = en_q && (sw_req || (trig_hit && !trig_prev));
  wire          start_ok = (st == S_IDLE) && en_q && req_q;
  wire          last_rd  = (idx == bn - IW'(1));
  wire          blk_end  = (st == S_END) && (blk_left == '0);
  wire          txn_end  = blk_end && !rpt_q;
  wire          do_arm   = arm && !en_q && (st == S_IDLE) && !disarm;

  assign bus_req   = (st != S_IDLE) && (st != S_END);
  assign bus_rd    = (st == S_RD);
  assign bus_wr    = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? dst_cur : src_cur;
  assign bus_wdata = buf_q[idx[2:0]];
  assign ch_en_o   = en_q;
  assign rpt_o     = rpt_q;
  assign req_o     = req_q;
  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_q;
  assign abort_o   = abort_q;

  always_ff @(posedge clk) begin
    if (rd_q) buf_q[cap_idx] <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      cap_idx <= '0;
      trig_prev <= 1'b0;
    end else begin
      rd_q    <= bus_rd;
      cap_idx <= idx[2:0];
      trig_prev <= trig_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      en_q <= 1'b0; rpt_q <= 1'b0; req_q <= 1'b0; ss_q <= 1'b0; blk_act <= 1'b0;
      done_q <= 1'b0; abort_q <= 1'b0;
      bl_q <= '0; smode <= '0; dmode <= '0; srld <= '0; drld <= '0;
      blk_init <= '0; blk_left <= '0; rep_left <= '0;
      src_init <= '0; dst_init <= '0; src_cur <= '0; dst_cur <= '0;
      tsel_q <= '0; idx <= '0; bn <= '0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;

      if (do_arm) begin
        en_q     <= 1'b1;
        rpt_q    <= cfg_rpt;
        ss_q     <= cfg_ss;
        bl_q     <= cfg_bl;
        smode    <= cfg_src_mode;
        dmode    <= cfg_dst_mode;
        srld     <= cfg_src_rld;
        drld     <= cfg_dst_rld;
        blk_init <= cfg_blk_cnt;
        blk_left <= {cfg_blk_cnt == 16'd0, cfg_blk_cnt};
        rep_left <= cfg_rep_cnt;
        src_init <= cfg_src;
        dst_init <= cfg_dst;
        src_cur  <= cfg_src;
        dst_cur  <= cfg_dst;
        tsel_q   <= cfg_trig_sel;
        blk_act  <= 1'b0;
        req_q    <= 1'b0;
      end

      if (start_ok) req_q <= 1'b0;
      if (new_req) req_q <= 1'b1;

      case (st)
        S_IDLE: if (start_ok) begin
          st <= S_REQ;
          if (!blk_act) begin
            blk_act <= 1'b1;
            if (rpt_q && rep_left == 8'd1) rpt_q <= 1'b0;
            if (rep_left != 8'd0) rep_left <= rep_left - 8'd1;
          end
        end
        S_REQ: begin
          if (!en_q) st <= S_IDLE;
          else if (bus_gnt) begin
            st  <= S_RD;
            idx <= '0;
            bn  <= bn_next;
          end
        end
        S_RD: begin
          src_cur  <= step(src_cur, smode);
          blk_left <= blk_left - BCW'(1);
          if (last_rd) begin
            st  <= S_RDL;
            idx <= '0;
          end else idx <= idx + IW'(1);
        end
        S_RDL: st <= S_WR;
        S_WR: begin
          dst_cur <= step(dst_cur, dmode);
          if (last_rd) begin
            st  <= S_END;
            idx <= '0;
          end else idx <= idx + IW'(1);
        end
        S_END: begin
          if (srld == RLD_BURST || (blk_end && srld == RLD_BLOCK) || (txn_end && srld == RLD_TXN))
            src_cur <= src_init;
          if (drld == RLD_BURST || (blk_end && drld == RLD_BLOCK) || (txn_end && drld == RLD_TXN))
            dst_cur <= dst_init;
          if (blk_end) begin
            blk_left <= {blk_init == 16'd0, blk_init};
            blk_act  <= 1'b0;
          end
          if (txn_end && en_q && !disarm) begin
            en_q   <= 1'b0;
            done_q <= 1'b1;
          end
          st <= (!blk_end && !ss_q && en_q && !disarm) ? S_REQ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (disarm && en_q) begin
        en_q <= 1'b0;
        if (!(txn_end && !disarm)) abort_q <= 1'b1;
      end
    end
  end

  AST_GNT_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(bus_gnt)); // R2
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> ($past(bus_wr) || !ch_en_o)); // R1
  AST_READS_THEN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> ($past(bus_rd, 2) && !$past(bus_rd))); // R3
  AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ch_en_o && !busy_o && $past(ch_en_o))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_RPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en_o && !rpt_o) |=> !rpt_o); // R5
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!done_o && !ch_en_o)); // R12

endmodule

// File: tb/dma_channel_tb.sv
module dma_channel_tb_top;
  localparam int AW = 16, NTRIG = 4, TSW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, disarm = 0, cfg_ss = 0, cfg_rpt = 0;
  logic [1:0] cfg_bl = 0, cfg_src_mode = 0, cfg_dst_mode = 0, cfg_src_rld = 0, cfg_dst_rld = 0;
  logic [15:0] cfg_blk_cnt = 0;
  logic [7:0] cfg_rep_cnt = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [TSW-1:0] cfg_trig_sel = 0;
  logic sw_req = 0;
  logic [NTRIG-1:0] hw_trig = 0;
  logic bus_req, bus_gnt, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata = 0;
  logic ch_en_o, rpt_o, req_o, busy_o, done_o, abort_o;
  logic host_hold = 0;

  int n_chk = 0, n_fail = 0;
  int wcnt = 0, rcnt = 0, nruns = 0, cur_run = 0, ndone = 0, nabort = 0;
  logic [7:0] mem [0:1023];
  int wlog_addr [0:1023];
  int wlog_data [0:1023];
  int run_len [0:255];
  logic pend_v = 0;
  logic [9:0] pend_a = 0;

  always #4 clk = ~clk;
  assign bus_gnt = bus_req & ~host_hold;

  dma_channel #(.AW(AW), .NTRIG(NTRIG), .TSW(TSW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .cfg_ss(cfg_ss), .cfg_rpt(cfg_rpt),
    .cfg_bl(cfg_bl), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
    .cfg_src_rld(cfg_src_rld), .cfg_dst_rld(cfg_dst_rld), .cfg_blk_cnt(cfg_blk_cnt),
    .cfg_rep_cnt(cfg_rep_cnt), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_trig_sel(cfg_trig_sel),
    .sw_req(sw_req), .hw_trig(hw_trig), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ch_en_o(ch_en_o), .rpt_o(rpt_o), .req_o(req_o),
    .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o));

  function automatic int sv(input int a);
    return (a * 7 + 3) & 255;
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(sv(i));

  always @(negedge clk) begin
    if (pend_v) bus_rdata <= mem[pend_a];
    pend_v <= bus_rd;
    pend_a <= bus_addr[9:0];
    if (bus_rd) rcnt <= rcnt + 1;
    if (bus_wr) begin
      mem[bus_addr[9:0]] <= bus_wdata;
      wlog_addr[wcnt] <= int'(bus_addr);
      wlog_data[wcnt] <= int'(bus_wdata);
      wcnt <= wcnt + 1;
      cur_run <= cur_run + 1;
    end else if (cur_run != 0) begin
      run_len[nruns] <= cur_run;
      nruns <= nruns + 1;
      cur_run <= 0;
    end
    if (done_o) ndone <= ndone + 1;
    if (abort_o) nabort <= nabort + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) sw_req = 1;
    @(negedge clk) sw_req = 0;
  endtask

  task automatic pulse_trig(input int k);
    @(negedge clk) hw_trig[k] = 1'b1;
    @(negedge clk) hw_trig[k] = 1'b0;
  endtask

  task automatic do_disarm();
    @(negedge clk) disarm = 1;
    @(negedge clk) disarm = 0;
  endtask

  task automatic setup(input bit ss, input bit rpt, input int bl, input int sm, input int dm,
                       input int sr, input int dr, input int cnt, input int rep,
                       input int src, input int dst, input int tsel);
    @(negedge clk);
    cfg_ss = ss; cfg_rpt = rpt; cfg_bl = 2'(bl);
    cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm); cfg_src_rld = 2'(sr); cfg_dst_rld = 2'(dr);
    cfg_blk_cnt = 16'(cnt); cfg_rep_cnt = 8'(rep);
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_trig_sel = TSW'(tsel);
    arm = 1;
    @(negedge clk) arm = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy_o && !req_o) break;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 bus_req", int'(bus_req), 0);
    chk("R13 busy", int'(busy_o), 0);
    chk("R13 en", int'(ch_en_o), 0);
    chk("R13 flags", int'({rpt_o, req_o, done_o, abort_o, bus_rd, bus_wr}), 0);
  endtask

  task automatic t_copy();
    int r0 = nruns, d0 = ndone, w0 = wcnt;
    setup(0, 0, 3, 1, 1, 0, 0, 20, 0, 'h010, 'h200, 0);
    chk("R11 en after arm", int'(ch_en_o), 1);
    pulse_req();
    wait_idle();
    chk("R9 block bytes", wcnt - w0, 20);
    for (int i = 0; i < 20; i++) chk("R7 inc copy data", int'(mem['h200 + i]), sv('h010 + i));
    chk("R3 runs", nruns - r0, 3);
    chk("R3 run0", run_len[r0], 8);
    chk("R3 run1", run_len[r0 + 1], 8);
    chk("R3 short run", run_len[r0 + 2], 4);
    chk("R6 done once", ndone - d0, 1);
    chk("R6 en cleared", int'(ch_en_o), 0);
    chk("R6 req cleared", int'(req_o), 0);
  endtask

  task automatic t_dec_fixed();
    int w0 = wcnt, r0 = nruns;
    setup(0, 0, 2, 2, 0, 0, 0, 5, 0, 'h0FF, 'h300, 0);
    pulse_req();
    wait_idle();
    chk("R7 dec bytes", wcnt - w0, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R7 fixed dst addr", wlog_addr[w0 + i], 'h300);
      chk("R7 dec src data", wlog_data[w0 + i], sv('h0FF - i));
    end
    chk("R3 bl4 run", run_len[r0], 4);
    chk("R3 bl4 short", run_len[r0 + 1], 1);
  endtask

  task automatic t_single_shot();
    int w0 = wcnt, d0 = ndone;
    setup(1, 0, 1, 1, 1, 0, 0, 6, 0, 'h0C0, 'h2C0, 0);
    pulse_req();
    wait_idle();
    chk("R9 one burst", wcnt - w0, 2);
    chk("R9 still enabled", int'(ch_en_o), 1);
    setup(0, 0, 3, 1, 1, 0, 0, 50, 0, 'h000, 'h3F0, 0);
    pulse_req();
    wait_idle();
    chk("R11 arm ignored, still one burst", wcnt - w0, 4);
    pulse_req();
    wait_idle();
    chk("R9 total", wcnt - w0, 6);
    chk("R6 ss done", ndone - d0, 1);
    for (int i = 0; i < 6; i++) chk("R11 ss data", int'(mem['h2C0 + i]), sv('h0C0 + i));
  endtask

  task automatic t_trigger();
    int w0 = wcnt;
    setup(0, 0, 3, 1, 1, 0, 0, 3, 0, 'h0D0, 'h2D0, 2);
    pulse_trig(0);
    repeat (10) @(negedge clk);
    chk("R10 wrong line ignored", wcnt - w0, 0);
    chk("R10 no pending", int'(req_o), 0);
    pulse_trig(1);
    wait_idle();
    chk("R10 selected line", wcnt - w0, 3);
    setup(0, 0, 3, 1, 1, 0, 0, 3, 0, 'h0D0, 'h2D8, 0);
    for (int k = 0; k < NTRIG; k++) pulse_trig(k);
    repeat (10) @(negedge clk);
    chk("R10 sel zero disables", wcnt - w0, 3);
    pulse_req();
    wait_idle();
    chk("R10 sw after sel zero", wcnt - w0, 6);
  endtask

  task automatic t_repeat_block();
    int w0 = wcnt, d0 = ndone;
    setup(0, 1, 3, 1, 1, 2, 0, 4, 3, 'h060, 'h260, 0);
    chk("R5 rpt set", int'(rpt_o), 1);
    pulse_req(); wait_idle();
    pulse_req(); wait_idle();
    chk("R5 rpt before last", int'(rpt_o), 1);
    chk("R4 two blocks", wcnt - w0, 8);
    chk("R5 no early done", ndone - d0, 0);
    pulse_req();
    repeat (2) @(negedge clk);
    chk("R5 rpt cleared at last start", int'(rpt_o), 0);
    chk("R5 busy in last", int'(busy_o), 1);
    wait_idle();
    chk("R5 three blocks", wcnt - w0, 12);
    chk("R5 done", ndone - d0, 1);
    for (int i = 0; i < 12; i++) chk("R8 block reload data", int'(mem['h260 + i]), sv('h060 + i % 4));
  endtask

  task automatic t_reload_burst();
    setup(0, 0, 2, 1, 1, 1, 0, 8, 0, 'h040, 'h240, 0);
    pulse_req(); wait_idle();
    for (int i = 0; i < 8; i++) chk("R8 burst reload data", int'(mem['h240 + i]), sv('h040 + i % 4));
  endtask

  task automatic t_reload_txn();
    int d0 = ndone;
    setup(0, 1, 0, 1, 1, 3, 3, 3, 2, 'h080, 'h280, 0);
    pulse_req(); wait_idle();
    pulse_req(); wait_idle();
    chk("R5 two blocks done", ndone - d0, 1);
    for (int i = 0; i < 6; i++) chk("R8 txn reload continues", int'(mem['h280 + i]), sv('h080 + i));
  endtask

  task automatic t_unlimited();
    int w0 = wcnt, d0 = ndone, a0 = nabort;
    setup(0, 1, 1, 1, 1, 0, 0, 2, 0, 'h0A0, 'h2A0, 0);
    for (int k = 0; k < 5; k++) begin pulse_req(); wait_idle(); end
    chk("R5 endless bytes", wcnt - w0, 10);
    chk("R5 endless no done", ndone - d0, 0);
    chk("R5 endless rpt", int'(rpt_o), 1);
    chk("R5 endless en", int'(ch_en_o), 1);
    for (int i = 0; i < 10; i++) chk("R4 endless data", int'(mem['h2A0 + i]), sv('h0A0 + i));
    do_disarm();
    @(negedge clk);
    chk("R12 abort pulse", nabort - a0, 1);
    chk("R12 en cleared", int'(ch_en_o), 0);
    chk("R12 no done", ndone - d0, 0);
  endtask

  task automatic t_count_zero();
    int w0 = wcnt, d0 = ndone;
    setup(1, 0, 3, 1, 1, 0, 0, 0, 0, 'h0E0, 'h2E0, 0);
    pulse_req(); wait_idle();
    chk("R4 zero count full burst", wcnt - w0, 8);
    chk("R4 zero count not done", ndone - d0, 0);
    do_disarm();
    setup(1, 0, 3, 1, 1, 0, 0, 1, 0, 'h0F0, 'h2F0, 0);
    pulse_req(); wait_idle();
    chk("R3 one byte block", wcnt - w0, 9);
    chk("R4 one byte done", ndone - d0, 1);
  endtask

  task automatic t_priority();
    int r0 = rcnt, rn = nruns, d0 = ndone;
    setup(0, 0, 3, 1, 1, 0, 0, 8, 0, 'h100, 'h320, 0);
    @(negedge clk) host_hold = 1;
    pulse_req();
    repeat (20) @(negedge clk);
    chk("R2 no read without grant", rcnt - r0, 0);
    chk("R2 request held", int'(bus_req), 1);
    host_hold = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bus_rd) break;
    end
    host_hold = 1;
    wait_idle();
    host_hold = 0;
    chk("R1 whole burst despite grant loss", run_len[rn], 8);
    chk("R2 reads", rcnt - r0, 8);
    chk("R6 done", ndone - d0, 1);
    for (int i = 0; i < 8; i++) chk("R1 priority data", int'(mem['h320 + i]), sv('h100 + i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..R13 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_copy();
    t_dec_fixed();
    t_single_shot();
    t_trigger();
    t_repeat_block();
    t_reload_burst();
    t_reload_txn();
    t_unlimited();
    t_count_zero();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule